// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block places a direct-mapped cache between a processor load/store port and a slower memory. Each line holds a valid bit, a tag made of the high address bits, and a block of one or more words. The line is chosen by the block address modulo the line count. Because that count is a power of two, the index is simply the low block-address bits. A read that hits returns data in the same cycle. A read that misses stalls the processor while the whole block is fetched, and the access then completes from the cache.

Stores follow a write-through, no-write-allocate policy. A store that hits updates the cached word. Every accepted store, hit or miss, is posted into a small FIFO write buffer that drains one word at a time to memory. The processor continues at once after a store and stalls only when the buffer is full. A store that misses never loads its block. Before a refill read is issued, the buffer is emptied, so memory never returns data older than a posted store.

The processor holds its request, address, write enable and write data steady while the stall output is high. An access completes on the rising edge where the request is high and the stall output is low.

Top module: `wtc_cache`

## Requirements
- R1: The byte address splits into byte offset (low bits), index (next log2(LINES) bits) and tag (all remaining high bits). Two addresses with the same index and different tags evict each other. With 64 lines of 16 bytes, address 1200 selects line 11.
- R2: After reset every line is invalid, and `cpu_stall`, `mem_rd_req` and `mem_wr_valid` are low. The first read of any address misses.
- R3: A read whose indexed line is valid with a matching tag completes with `cpu_stall` low in its first cycle, returns the cached word and issues no memory read.
- R4: A read miss raises `cpu_stall` in the same cycle as the request. It fetches the whole block through the block read channel and then completes with the fetched word.
- R5: With 8 lines of one word, reads of word addresses 22, 26, 22, 26, 16, 3, 16, 18 in that order give miss, miss, hit, hit, miss, miss, hit, miss.
- R6: A store that hits updates the cached word, so a following read hits and returns the new value. The store is also written to memory.
- R7: A store that misses issues no block read and loads nothing into the cache. The word reaches memory only, and a later read of that address misses.
- R8: A store is accepted without a stall whenever the write buffer has a free entry.
- R9: The write buffer holds WB_DEPTH entries. A store that finds it full keeps `cpu_stall` high until an entry leaves.
- R10: Buffered stores leave on the memory write channel in the order they were accepted, one word per cycle in which `mem_wr_valid` and `mem_wr_ready` are both high.
- R11: On a read miss, `mem_rd_req` stays low until the write buffer is empty. The refilled block therefore includes every earlier store.
- R12: `mem_rd_req` and `mem_rd_addr` hold until `mem_rd_valid`. `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold while `mem_wr_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when the load completes |
| cpu_stall | output | 1 | Processor must hold its request this cycle |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_addr | output | ADDR_W | Block-aligned byte address of the refill |
| mem_rd_valid | input | 1 | Block read data present, ends the request |
| mem_rd_data | input | DATA_W*WORDS | Whole block, word 0 in the low bits |
| mem_wr_valid | output | 1 | Write buffer head is offered to memory |
| mem_wr_addr | output | ADDR_W | Byte address of the offered word |
| mem_wr_data | output | DATA_W | Offered word |
| mem_wr_ready | input | 1 | Memory takes the offered word this cycle |

## Verification
The bench builds the cache with 8 lines of one 32-bit word and a 4-entry write buffer. With these values the index is three address bits, so the eight-access hit/miss sequence and conflict evictions between nearby word addresses can be reproduced exactly. A full buffer can also be reached with four stores while the bench holds the memory write channel closed. Holding that channel closed during a read miss makes the drain-before-refill ordering and the stability of the offered write visible for as many cycles as needed.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_DRAIN = 2'd1,
        FS_FILL  = 2'd2
    } fill_state_e;

    // width of a selector for n choices, never below one bit
    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wtc_lines.sv
module wtc_lines #(
    parameter int LINES  = 64,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int SEL_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          lk_idx,
    input  logic [TAG_W-1:0]          lk_tag,
    output logic                      lk_hit,
    output logic [DATA_W*WORDS-1:0]   lk_line,
    input  logic                      fill_en,
    input  logic [DATA_W*WORDS-1:0]   fill_line,
    input  logic                      upd_en,
    input  logic [SEL_W-1:0]          upd_sel,
    input  logic [DATA_W-1:0]         upd_data
);
    localparam int LINE_W = DATA_W * WORDS;

    logic [LINES-1:0]  vld;
    logic [TAG_W-1:0]  tags [LINES];
    logic [LINE_W-1:0] body [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (fill_en) begin
            vld[lk_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tags[lk_idx] <= lk_tag;
            body[lk_idx] <= fill_line;
        end else if (upd_en) begin
            body[lk_idx][upd_sel*DATA_W +: DATA_W] <= upd_data;
        end
    end

    assign lk_hit  = vld[lk_idx] && (tags[lk_idx] == lk_tag);
    assign lk_line = body[lk_idx];

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  level
);
    localparam int PTR_W = wtc_pkg::sel_width(DEPTH);

    logic [ADDR_W-1:0] q_addr [DEPTH];
    logic [DATA_W-1:0] q_data [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            q_addr[wp] <= push_addr;
            q_data[wp] <= push_data;
        end
    end

    assign head_addr = q_addr[rp];
    assign head_data = q_data[rp];
    assign empty     = (cnt == '0);
    assign full      = (cnt == CNT_W'(DEPTH));
    assign level     = cnt;

endmodule

// File: rtl/wtc_fill_fsm.sv
module wtc_fill_fsm
    import wtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_miss,
    input  logic        wb_empty,
    input  logic        line_arrived,
    output fill_state_e state,
    output logic        fill_req
);
    fill_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE:  if (rd_miss) nxt = wb_empty ? FS_FILL : FS_DRAIN;
            FS_DRAIN: if (wb_empty) nxt = FS_FILL;
            FS_FILL:  if (line_arrived) nxt = FS_IDLE;
            default:  nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FS_IDLE;
        else     state <= nxt;
    end

    assign fill_req = (state == FS_FILL);

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LINES    = 64,
    parameter int WORDS    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_stall,
    output logic                     mem_rd_req,
    output logic [ADDR_W-1:0]        mem_rd_addr,
    input  logic                     mem_rd_valid,
    input  logic [DATA_W*WORDS-1:0]  mem_rd_data,
    output logic                     mem_wr_valid,
    output logic [ADDR_W-1:0]        mem_wr_addr,
    output logic [DATA_W-1:0]        mem_wr_data,
    input  logic                     mem_wr_ready
);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 0;
    localparam int SEL_W  = sel_width(WORDS);
    localparam int OFF_W  = BOFF_W + WOFF_W;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = DATA_W * WORDS;
    localparam int CNT_W  = $clog2(WB_DEPTH + 1);

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [SEL_W-1:0]  word_sel;
    logic [LINE_W-1:0] line_q;
    logic              hit;
    logic              idle;
    logic              rd_miss;
    logic              wr_go;
    logic              wb_pop;
    logic              wb_empty;
    logic              wb_full;
    logic [CNT_W-1:0]  wb_level;
    logic              fill_req;
    logic              fill_en;
    fill_state_e       state;
    logic              unused_low;

    assign idx        = cpu_addr[OFF_W +: IDX_W];
    assign tag        = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_low = ^cpu_addr[BOFF_W-1:0];

    generate
        if (WORDS > 1) begin : g_multi
            assign word_sel  = cpu_addr[BOFF_W +: SEL_W];
            assign cpu_rdata = line_q[word_sel*DATA_W +: DATA_W];
        end else begin : g_single
            assign word_sel  = '0;
            assign cpu_rdata = line_q[DATA_W-1:0];
        end
    endgenerate

    assign idle    = (state == FS_IDLE);
    assign rd_miss = cpu_req && !cpu_we && !hit && idle;
    assign wr_go   = cpu_req && cpu_we && idle && !wb_full;
    assign wb_pop  = !wb_empty && mem_wr_ready;
    assign fill_en = fill_req && mem_rd_valid;

    assign cpu_stall = cpu_req &&
                       (!idle || (!cpu_we && !hit) || (cpu_we && wb_full));

    wtc_lines #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .WORDS (WORDS),
        .SEL_W (SEL_W)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (idx),
        .lk_tag   (tag),
        .lk_hit   (hit),
        .lk_line  (line_q),
        .fill_en  (fill_en),
        .fill_line(mem_rd_data),
        .upd_en   (wr_go && hit),
        .upd_sel  (word_sel),
        .upd_data (cpu_wdata)
    );

    wtc_wbuf #(
        .DEPTH (WB_DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .push     (wr_go),
        .push_addr(cpu_addr),
        .push_data(cpu_wdata),
        .pop      (wb_pop),
        .head_addr(mem_wr_addr),
        .head_data(mem_wr_data),
        .empty    (wb_empty),
        .full     (wb_full),
        .level    (wb_level)
    );

    wtc_fill_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .rd_miss     (rd_miss),
        .wb_empty    (wb_empty),
        .line_arrived(mem_rd_valid),
        .state       (state),
        .fill_req    (fill_req)
    );

    assign mem_rd_req   = fill_req;
    assign mem_rd_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wr_valid = !wb_empty;

endmodule

// File: rtl/wtc_chk.sv
module wtc_chk #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_stall,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              wb_empty,
    input logic [CNT_W-1:0]  wb_level
);
    // R11
    refill_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> wb_empty);

    // R9
    wb_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wb_level <= CNT_W'(DEPTH));

    // R8
    store_posted_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall) |=> !wb_empty);

    // R4
    fill_completes_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid && cpu_req && !cpu_we) |=> (!cpu_req || !cpu_stall));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

endmodule

bind wtc_cache wtc_chk #(
    .DEPTH (WB_DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_stall   (cpu_stall),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .wb_empty    (wb_empty),
    .wb_level    (wb_level)
);

// File: tb/sim_wtc_cache.sv
`timescale 1ns/1ps
module sim_wtc_cache;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int NL  = 8;
    localparam int WPL = 1;
    localparam int WBD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_stall;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_valid;
    logic [DW*WPL-1:0] mem_rd_data;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_wr_ready;
    logic          wr_ready_en = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wtc_cache #(
        .ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WORDS(WPL), .WB_DEPTH(WBD)
    ) u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
    );

    // memory model: 64 words, word i starts as A000_0000 + i
    logic [31:0] mem_model [64];
    logic [31:0] wlog [64];
    int rd_count;
    int wn;
    int lat;

    assign mem_wr_ready = wr_ready_en;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem_model[i] <= 32'hA000_0000 + i;
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
            lat      <= 0;
            rd_count <= 0;
            wn       <= 0;
        end else begin
            if (mem_rd_req && mem_rd_valid) begin
                mem_rd_valid <= 1'b0;
                lat          <= 0;
                rd_count     <= rd_count + 1;
            end else if (mem_rd_req) begin
                if (lat == 2) begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= mem_model[mem_rd_addr[7:2]];
                end else begin
                    lat <= lat + 1;
                end
            end
            if (mem_wr_valid && mem_wr_ready) begin
                mem_model[mem_wr_addr[7:2]] <= mem_wr_data;
                wlog[wn[5:0]] <= mem_wr_addr;
                wn <= wn + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input int word, input logic [31:0] wd,
                          output logic [31:0] rd, output logic first_stall);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(word * 4); cpu_wdata = wd;
        #1;
        first_stall = cpu_stall;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd_expect(input string req, input int word, input logic miss,
                             input logic [31:0] exp);
        logic [31:0] rd;
        logic st;
        int c0;
        c0 = rd_count;
        access(1'b0, word, '0, rd, st);
        check({req, " miss"}, 32'(rd_count != c0), 32'(miss));
        check({req, " stall"}, 32'(st), 32'(miss));
        check({req, " data"}, rd, exp);
    endtask

    // R2, R3, R4, R5
    task automatic t_sequence();
        int words [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
        bit miss [8] = '{1, 1, 0, 0, 1, 1, 0, 1};
        @(negedge clk);
        check("R2 stall idle", 32'(cpu_stall), 0);
        check("R2 rd_req idle", 32'(mem_rd_req), 0);
        check("R2 wr_valid idle", 32'(mem_wr_valid), 0);
        for (int k = 0; k < 8; k++)
            rd_expect(miss[k] ? "R5 R4" : "R5 R3", words[k], miss[k],
                      32'hA000_0000 + words[k]);
    endtask

    // R1: words 26, 10, 18 share index 2
    task automatic t_conflict();
        rd_expect("R1 evict 18", 26, 1, 32'hA000_001A);
        rd_expect("R1 evict 26", 10, 1, 32'hA000_000A);
        rd_expect("R1 reload 26", 26, 1, 32'hA000_001A);
        rd_expect("R1 other line", 3, 0, 32'hA000_0003);
    endtask

    // R6, R8
    task automatic t_write_hit();
        logic [31:0] rd;
        logic st;
        int c0;
        c0 = rd_count;
        access(1'b1, 3, 32'h1234_5678, rd, st);
        check("R8 store no stall", 32'(st), 0);
        check("R6 no refill", 32'(rd_count - c0), 0);
        rd_expect("R6 read back", 3, 0, 32'h1234_5678);
        repeat (6) @(negedge clk);
        check("R6 memory updated", mem_model[3], 32'h1234_5678);
    endtask

    // R7
    task automatic t_write_miss();
        logic [31:0] rd;
        logic st;
        int c0;
        c0 = rd_count;
        access(1'b1, 5, 32'h0BAD_F00D, rd, st);
        check("R7 store no stall", 32'(st), 0);
        check("R7 no block read", 32'(rd_count - c0), 0);
        repeat (6) @(negedge clk);
        check("R7 memory updated", mem_model[5], 32'h0BAD_F00D);
        rd_expect("R7 later read", 5, 1, 32'h0BAD_F00D);
    endtask

    // R8, R9, R10
    task automatic t_full();
        logic [31:0] rd;
        logic st;
        int n0;
        n0 = wn;
        wr_ready_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            access(1'b1, 40 + k, 32'hC0DE_0040 + k, rd, st);
            check("R8 posted store", 32'(st), 0);
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(44 * 4); cpu_wdata = 32'hC0DE_0044;
        #1;
        check("R9 full stall", 32'(cpu_stall), 1);
        repeat (3) begin
            @(negedge clk);
            #1;
        end
        check("R9 still stalled", 32'(cpu_stall), 1);
        check("R9 nothing drained", 32'(wn - n0), 0);
        wr_ready_en = 1'b1;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 drained count", 32'(wn - n0), 5);
        for (int k = 0; k < 5; k++) begin
            check("R10 order", wlog[(n0 + k) % 64], 32'((40 + k) * 4));
            check("R10 memory data", mem_model[40 + k], 32'hC0DE_0040 + k);
        end
    endtask

    // R11, R12
    task automatic t_order();
        logic [31:0] rd;
        logic st;
        int c0;
        wr_ready_en = 1'b0;
        access(1'b1, 50, 32'h5050_0050, rd, st);
        access(1'b1, 51, 32'h5151_0051, rd, st);
        c0 = rd_count;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(50 * 4);
        #1;
        for (int k = 0; k < 5; k++) begin
            check("R11 stalled", 32'(cpu_stall), 1);
            check("R11 no refill yet", 32'(mem_rd_req), 0);
            check("R12 write held", 32'(mem_wr_valid), 1);
            check("R12 write addr held", mem_wr_addr, 32'(50 * 4));
            @(negedge clk);
            #1;
        end
        wr_ready_en = 1'b1;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        check("R11 fresh data", rd, 32'h5050_0050);
        check("R11 one refill", 32'(rd_count - c0), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_sequence();
        t_conflict();
        t_write_hit();
        t_write_miss();
        t_full();
        t_order();
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule